// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is an I2C target that serves a 256-byte, byte-addressed memory to a bus controller. It oversamples SCL and SDA on a fast system clock and finds START, repeated START and STOP conditions. It answers only to control bytes that carry its own 7-bit device address, and it pulls SDA low through an open-drain enable to send acknowledges and read data.

The target keeps one 8-bit address pointer, and that pointer survives from one transaction to the next. A controller has three ways to read. It can issue a bare read, which continues from the byte after the last one accessed. It can first write a word address and then issue a repeated START followed by a read. It can keep acknowledging bytes to stream through the array, and the stream wraps from the top address to the bottom one. If further bytes follow the word address in a write transaction, they are stored in the array.

A separate load port fills the array directly so that a test environment can set its initial contents.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset SDA is released (`sda_drive_low` = 0) and the address pointer is 0, so the first bare read returns the byte at address 0x00.
- R2: A control byte has the device address in bits 7..1 and the read flag in bit 0. When bits 7..1 equal `DEV_ADDR`, the target pulls SDA low in the 9th clock. When they do not, the target does not acknowledge, does not pull SDA low, and ignores every following byte until the next START.
- R3: A random read is a write-type control byte (bit 0 = 0), one word-address byte, a repeated START, and a read-type control byte (bit 0 = 1). It returns the byte stored at that word address.
- R4: A repeated START that follows the word-address acknowledge ends the write phase. The word address is kept as the pointer, and no array location is changed.
- R5: A bare read returns the byte one past the last byte accessed, whether that byte was read or written in an earlier transaction.
- R6: While the controller acknowledges read bytes, the target sends the byte at the next address each time. After address 0xFF it continues at 0x00.
- R7: When the controller does not acknowledge a read byte, the target releases SDA from the falling edge that ends that slot until the next START. The pointer then holds the address after the last byte sent.
- R8: In a write transaction, each data byte after the word address is acknowledged and stored at the pointer, and the pointer then advances by one.
- R9: The target begins pulling SDA low only while SCL is low.
- R10: Read data is shifted out most significant bit first, one bit per SCL clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it (open drain) |
| bd_we | input | 1 | Load-port write strobe |
| bd_addr | input | 8 | Load-port byte address |
| bd_data | input | 8 | Load-port byte value |

## Verification
A wrong pointer shows up in the very next data byte on SDA, because each read returns the array byte at the pointer. The bench keeps its own expected pointer across transactions, so pointer drift is caught at the first bare read that follows. A wrong phase or bit count shows up in the same 9-clock slot, as an acknowledge that is missing, an acknowledge where none belongs, or data that is shifted by one bit. A write that leaks through after a repeated START, or after an address mismatch, stays hidden until that location is read back. For that reason the bench reads back the locations such stimulus could have changed.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_drive_low,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [7:0]    bd_data
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {P_IDLE, P_CTRL, P_ADDR, P_WR, P_RD} phase_t;

  logic [2:0] scl_sy, sda_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_sy[1];
  assign scl_old = scl_sy[2];
  assign sda_now = sda_sy[1];
  assign sda_old = sda_sy[2];

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;

  phase_t        phase;
  logic [3:0]    bitcnt;
  logic [7:0]    rx, tx;
  logic [AW-1:0] ptr;
  logic          rd_go, drv;
  logic [7:0]    mem [DEPTH];

  logic wr_en;
  assign wr_en = ~start_det & ~stop_det & scl_fall & (bitcnt == 4'd8) & (phase == P_WR);

  always_ff @(posedge clk)
    if (bd_we)      mem[bd_addr] <= bd_data;
    else if (wr_en) mem[ptr]     <= rx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= P_IDLE;
      bitcnt <= '0;
      rx     <= '0;
      tx     <= '0;
      ptr    <= '0;
      rd_go  <= 1'b0;
      drv    <= 1'b0;
    end else if (start_det) begin
      phase  <= P_CTRL;
      bitcnt <= '0;
      drv    <= 1'b0;
    end else if (stop_det) begin
      phase  <= P_IDLE;
      bitcnt <= '0;
      drv    <= 1'b0;
    end else if (phase != P_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) rx <= {rx[6:0], sda_now};
        else               rd_go <= ~sda_now;
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          drv <= 1'b0;
          case (phase)
            P_CTRL:
              if (rx[7:1] == DEV_ADDR) begin
                drv   <= 1'b1;
                phase <= rx[0] ? P_RD : P_ADDR;
              end else begin
                phase <= P_IDLE;
              end
            P_ADDR: begin
              ptr   <= rx[AW-1:0];
              drv   <= 1'b1;
              phase <= P_WR;
            end
            P_WR: begin
              ptr <= ptr + 1'b1;
              drv <= 1'b1;
            end
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (phase == P_RD && rd_go) begin
            tx  <= mem[ptr];
            drv <= ~mem[ptr][7];
            ptr <= ptr + 1'b1;
          end else begin
            drv <= 1'b0;
            if (phase == P_RD) phase <= P_IDLE;
          end
        end else if (phase == P_RD && bitcnt != 4'd0) begin
          drv <= ~tx[3'd7 - bitcnt[2:0]];
        end
      end
    end

  assign sda_drive_low = drv;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_drive_low,
  input logic          stop_det,
  input logic [2:0]    phase,
  input logic [AW-1:0] ptr
);
  assert_released_at_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sda_drive_low);

  assert_idle_never_pulls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> !sda_drive_low);

  assert_ptr_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 3'd4 && $past(ptr) == {AW{1'b1}} && ptr != $past(ptr)) |-> ptr == '0);

  assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low);

  assert_pull_only_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_i);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_drive_low(sda_drive_low),
  .stop_det(stop_det), .phase(phase), .ptr(ptr)
);

// File: tb/i2c_mem_target_bench.sv
module i2c_mem_target_bench;
  localparam logic [6:0] DEV = 7'h50;
  localparam int Q = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic bd_we = 1'b0;
  logic [7:0] bd_addr = '0, bd_data = '0;
  logic sda_drive_low, bus_sda;
  int checks = 0, errors = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] exp_ptr;

  always #5 clk = ~clk;
  assign bus_sda = sda_m & ~sda_drive_low;

  i2c_mem_target #(.DEV_ADDR(DEV), .AW(8)) u_i2c_mem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .sda_drive_low(sda_drive_low), .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data));

  // {start address, byte count}
  localparam logic [15:0] VEC [6] = '{16'h0002, 16'h3C01, 16'hA503, 16'hFE04, 16'h7F02, 16'h1005};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic start_c(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic stop_c(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
  task automatic wbit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); endtask
  task automatic rbit(output logic b); sda_m = 1; wq(); scl_m = 1; wq(); b = bus_sda; wq(); scl_m = 0; wq(); endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~mack);
  endtask

  task automatic cur_read(input string tag);
    logic a;
    logic [7:0] d;
    start_c();
    send_byte({DEV, 1'b1}, a);
    chk(a, tag, a, 1);
    recv_byte(d, 1'b0);
    chk(d == ref_mem[exp_ptr], tag, d, ref_mem[exp_ptr]);
    chk(!sda_drive_low, {tag, " R7 release"}, sda_drive_low, 0);
    stop_c();
    exp_ptr++;
  endtask

  initial begin
    logic a;
    logic [7:0] d, st;
    int n;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'((i * 37 + 11) & 255);
    repeat (4) @(negedge clk);
    chk(!sda_drive_low, "R1 reset release", sda_drive_low, 0);
    rst_n = 1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      bd_we = 1; bd_addr = 8'(i); bd_data = ref_mem[i];
    end
    @(negedge clk); bd_we = 0;
    repeat (10) @(negedge clk);
    chk(!sda_drive_low, "R1 idle release", sda_drive_low, 0);

    exp_ptr = 8'h00;
    cur_read("R1 R5 first bare read");

    for (int v = 0; v < 6; v++) begin
      st = VEC[v][15:8];
      n  = int'(VEC[v][7:0]);
      start_c();
      send_byte({DEV, 1'b0}, a); chk(a, "R2 ctrl ack", a, 1);
      send_byte(st, a);          chk(a, "R3 addr ack", a, 1);
      start_c();
      send_byte({DEV, 1'b1}, a); chk(a, "R3 read ack", a, 1);
      for (int k = 0; k < n; k++) begin
        recv_byte(d, k != n - 1);
        chk(d == ref_mem[8'(st + k)], "R3 R6 R10 data", d, ref_mem[8'(st + k)]);
      end
      chk(!sda_drive_low, "R7 release after nack", sda_drive_low, 0);
      stop_c();
      exp_ptr = 8'(st + n);
      cur_read("R5 R7 pointer after read");
    end

    start_c();
    send_byte({DEV, 1'b0}, a); send_byte(8'h20, a);
    send_byte(8'hAA, a); chk(a, "R8 data ack", a, 1);
    send_byte(8'h55, a); chk(a, "R8 data ack", a, 1);
    send_byte(8'hC3, a); chk(a, "R8 data ack", a, 1);
    stop_c();
    ref_mem[8'h20] = 8'hAA; ref_mem[8'h21] = 8'h55; ref_mem[8'h22] = 8'hC3;
    exp_ptr = 8'h23;
    cur_read("R8 R5 pointer after write");
    start_c();
    send_byte({DEV, 1'b0}, a); send_byte(8'h1F, a);
    start_c();
    send_byte({DEV, 1'b1}, a);
    for (int k = 0; k < 5; k++) begin
      recv_byte(d, k != 4);
      chk(d == ref_mem[8'h1F + k], "R8 stored bytes", d, ref_mem[8'h1F + k]);
    end
    stop_c();

    start_c();
    send_byte({DEV, 1'b0}, a); send_byte(8'h50, a);
    stop_c();
    exp_ptr = 8'h50;
    cur_read("R4 pointer kept without data");

    start_c();
    send_byte({DEV, 1'b0}, a); send_byte(8'h40, a);
    start_c();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b0);
    chk(d == ref_mem[8'h40], "R4 no write on repeated start", d, ref_mem[8'h40]);
    stop_c();
    exp_ptr = 8'h41;

    start_c();
    send_byte({7'h51, 1'b0}, a); chk(!a, "R2 mismatch no ack", a, 0);
    send_byte(8'h30, a);         chk(!a, "R2 ignored addr", a, 0);
    send_byte(8'h99, a);         chk(!a, "R2 ignored data", a, 0);
    stop_c();
    cur_read("R2 pointer untouched by mismatch");
    start_c();
    send_byte({DEV, 1'b0}, a); send_byte(8'h30, a);
    start_c();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b0);
    chk(d == ref_mem[8'h30], "R2 array untouched by mismatch", d, ref_mem[8'h30]);
    stop_c();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule